// File: doc/BRIEF.md
# SMBus Slave Read Engine with Packet Error Code

This block is a slave on a two-wire SMBus/I2C bus that answers read transactions from a byte memory beside it. SCL and SDA pass through synchronizers into the system clock domain. The block pulls SDA low through an output-enable and never drives it high. It answers to one 7-bit address, set by parameter. It holds an address pointer into the memory. The memory is a plain synchronous read port: the block presents an address and the byte arrives on the next clock.

A write transaction that carries one byte loads the pointer from that byte. A read transaction of one byte returns the byte at the pointer. A write of the block-read command code, then a repeated start and a read, returns three things in order. First comes a count byte. Then come 32 bytes from consecutive memory locations. Last comes an optional checksum byte, a CRC-8 taken over the whole transaction. The pointer moves forward with every data byte it delivers, so reads can be chained.

Top module: `smbrd_engine`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal the SLAVE_ADDR parameter (0x2A by default). After any other address it leaves SDA released and ignores the bus until the next start, so no pointer load takes place.
- R2: After an acknowledged address with bit 0 = 0 (write), a following byte other than 0xFD is acknowledged. Its low MEM_AW bits (6 by default) are copied into the pointer, which appears on `memAddr`.
- R3: After an acknowledged address with bit 0 = 1 (read) that does not follow a block command, the slave sends the memory byte at the pointer, MSB first. The pointer then advances by one.
- R4: The sequence write address, 0xFD, repeated start, read address is acknowledged at every byte. The slave then sends 0x20 followed by 32 bytes from consecutive locations that begin at the pointer. The pointer ends 32 higher.
- R5: The pointer wraps from the last location (2^MEM_AW - 1) to 0 in the middle of a block.
- R6: With `pecEn` = 1, once the master acknowledges the 32nd data byte, the slave sends one more byte. That byte is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) of every byte on the bus since the opening start: write address, 0xFD, read address, count and data. The repeated start that follows 0xFD does not clear it.
- R7: With `pecEn` = 0, nothing follows the 32nd data byte. SDA stays released if the master keeps clocking.
- R8: If the master answers a data byte with NACK before the last expected byte, the slave releases SDA for the rest of the transaction. The pointer keeps the advance for the bytes already sent.
- R9: A stop or start condition at any point, including in the middle of a byte, returns the slave to address matching. A stop also cancels a pending block command, so a later read returns a single data byte.
- R10: SDA changes only while SCL is low. The acknowledge and every data bit stay constant through the whole high phase of their clock.
- R11: After reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| pecEn | input | 1 | 1 appends the CRC-8 byte after a block |
| memAddr | output | MEM_AW | Memory read address, equal to the pointer |
| memData | input | 8 | Memory read data, one clock after the address |

## Verification
A bit-level master drives the bus in several patterns. Single-byte reads check that the pointer advances between reads. A foreign address checks that the address compare is exact and that nothing else happens. A full block read with the checksum starts near the top of the memory, so the wrap and the CRC, which includes the bytes before the repeated start, are tested on the same run. A block read without the checksum, with extra clocks after it, separates "done" from "one more byte". An early NACK, a stop after the block command, and a restart in the middle of a byte test the three ways a transaction can end early. Each is checked through the pointer value and the byte that the next read returns.

// File: rtl/smbrd_pkg.sv
package smbrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_RX,     // shifting in an address or command byte
    ST_RXACK,  // slave holding SDA low for the ninth clock
    ST_TX,     // shifting out a byte
    ST_TXACK   // master answering a sent byte
  } state_e;

  typedef struct packed {
    logic clrCrc;
    logic crcStep;
    logic rxShift;
    logic txShift;
    logic loadTxMem;
    logic loadTxCount;
    logic loadTxPec;
    logic loadPtr;
    logic incPtr;
  } strobe_t;

  // one MSB-first step of CRC-8, polynomial x^8 + x^2 + x + 1
  function automatic logic [7:0] crc8Step(logic [7:0] cur, logic bitIn);
    logic fb;
    fb = cur[7] ^ bitIn;
    return {cur[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction

endpackage

// File: rtl/smbrd_dp.sv
module smbrd_dp
  import smbrd_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int BLOCK_LEN   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           strobe,
  input  logic [7:0]        memData,
  output logic [MEM_AW-1:0] memAddr,
  output logic              sclLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [7:0]        crcVal
);

  localparam logic [7:0] COUNT_BYTE = 8'(BLOCK_LEN);
  localparam int         TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclPipe, sdaPipe;
  logic         sclPrev, sdaPrev;
  logic [7:0]   rxReg, txReg, crcReg;
  logic [MEM_AW-1:0] ptr;

  // synchronizer chains, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else begin
          sclPipe[g] <= sclPipe[g-1];
          sdaPipe[g] <= sdaPipe[g-1];
        end
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[TOP];
      sdaPrev <= sdaPipe[TOP];
    end

  assign sclLevel = sclPipe[TOP];
  assign sdaBit   = sdaPipe[TOP];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaBit;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaBit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxReg  <= '0;
      txReg  <= 8'hFF;
      crcReg <= '0;
      ptr    <= '0;
    end else begin
      if (strobe.rxShift) rxReg <= {rxReg[6:0], sdaBit};

      if (strobe.loadTxMem)        txReg <= memData;
      else if (strobe.loadTxCount) txReg <= COUNT_BYTE;
      else if (strobe.loadTxPec)   txReg <= crcReg;
      else if (strobe.txShift)     txReg <= {txReg[6:0], 1'b1};

      if (strobe.clrCrc)       crcReg <= '0;
      else if (strobe.crcStep) crcReg <= crc8Step(crcReg, sdaBit);

      if (strobe.loadPtr)     ptr <= rxReg[MEM_AW-1:0];
      else if (strobe.incPtr) ptr <= ptr + 1'b1;
    end

  assign memAddr = ptr;
  assign rxByte  = rxReg;
  assign txMsb   = txReg[7];
  assign crcVal  = crcReg;

endmodule

// File: rtl/smbrd_ctrl.sv
module smbrd_ctrl
  import smbrd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A,
  parameter logic [7:0] BLOCK_CMD  = 8'hFD,
  parameter int         BLOCK_LEN  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaBit,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       pecEn,
  output strobe_t    strobe,
  output logic       sdaOe,
  output state_e     state,
  output logic       armed
);

  localparam int IDXW = $clog2(BLOCK_LEN + 2);
  localparam logic [IDXW-1:0] LAST_DATA = IDXW'(BLOCK_LEN);
  localparam logic [IDXW-1:0] PEC_IDX   = IDXW'(BLOCK_LEN + 1);

  state_e          stateN;
  logic [3:0]      bitCnt, bitCntN;
  logic            rxIsAddr, rxIsAddrN, isRead, isReadN, armedN;
  logic            blockMode, blockModeN, masterAck, masterAckN;
  logic [IDXW-1:0] byteIdx, byteIdxN;
  logic            isData;

  assign isData = !blockMode || (byteIdx != '0 && byteIdx <= LAST_DATA);

  always_comb begin
    stateN     = state;
    bitCntN    = bitCnt;
    rxIsAddrN  = rxIsAddr;
    isReadN    = isRead;
    armedN     = armed;
    blockModeN = blockMode;
    masterAckN = masterAck;
    byteIdxN   = byteIdx;
    strobe     = '0;
    if (stopDet) begin
      stateN = ST_IDLE;
      armedN = 1'b0;
    end else if (startDet) begin
      stateN        = ST_RX;
      bitCntN       = '0;
      rxIsAddrN     = 1'b1;
      strobe.clrCrc = !armed;
    end else if (sclRise) begin
      unique case (state)
        ST_RX: begin
          strobe.rxShift = 1'b1;
          strobe.crcStep = 1'b1;
          bitCntN        = bitCnt + 1'b1;
        end
        ST_TX: begin
          strobe.crcStep = 1'b1;
          bitCntN        = bitCnt + 1'b1;
        end
        ST_TXACK: masterAckN = !sdaBit;
        default: ;
      endcase
    end else if (sclFall) begin
      unique case (state)
        ST_RX: if (bitCnt == 4'd8) begin
          if (rxIsAddr) begin
            if (rxByte[7:1] == SLAVE_ADDR) begin
              stateN  = ST_RXACK;
              isReadN = rxByte[0];
            end else begin
              stateN = ST_IDLE;
              armedN = 1'b0;
            end
          end else begin
            stateN = ST_RXACK;
            if (rxByte == BLOCK_CMD) armedN = 1'b1;
            else begin
              strobe.loadPtr = 1'b1;
              armedN         = 1'b0;
            end
          end
        end
        ST_RXACK: begin
          bitCntN = '0;
          if (rxIsAddr && isRead) begin
            stateN     = ST_TX;
            blockModeN = armed;
            byteIdxN   = '0;
            armedN     = 1'b0;
            if (armed) strobe.loadTxCount = 1'b1;
            else       strobe.loadTxMem   = 1'b1;
          end else if (rxIsAddr) begin
            stateN    = ST_RX;
            rxIsAddrN = 1'b0;
          end else begin
            stateN = ST_IDLE;
          end
        end
        ST_TX: begin
          if (bitCnt == 4'd8) begin
            stateN        = ST_TXACK;
            strobe.incPtr = isData;
          end else begin
            strobe.txShift = 1'b1;
          end
        end
        ST_TXACK: begin
          bitCntN = '0;
          if (!blockMode || byteIdx == PEC_IDX || !masterAck) begin
            stateN = ST_IDLE;
          end else if (byteIdx == LAST_DATA) begin
            if (pecEn) begin
              stateN           = ST_TX;
              strobe.loadTxPec = 1'b1;
              byteIdxN         = byteIdx + 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end else begin
            stateN           = ST_TX;
            strobe.loadTxMem = 1'b1;
            byteIdxN         = byteIdx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxIsAddr  <= 1'b0;
      isRead    <= 1'b0;
      armed     <= 1'b0;
      blockMode <= 1'b0;
      masterAck <= 1'b0;
      byteIdx   <= '0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      rxIsAddr  <= rxIsAddrN;
      isRead    <= isReadN;
      armed     <= armedN;
      blockMode <= blockModeN;
      masterAck <= masterAckN;
      byteIdx   <= byteIdxN;
    end

  // only state registers feed the pin, so it moves once per bus event
  assign sdaOe = (state == ST_RXACK) || (state == ST_TX && !txMsb);

endmodule

// File: rtl/smbrd_engine.sv
module smbrd_engine
  import smbrd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter logic [7:0] BLOCK_CMD   = 8'hFD,
  parameter int         BLOCK_LEN   = 32,
  parameter int         MEM_AW      = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              pecEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memData
);

  strobe_t    strobe;
  logic       sclLevel, sclRise, sclFall, startDet, stopDet, sdaBit, txMsb;
  logic [7:0] rxByte, crcVal;
  state_e     state;
  logic       armed, incPtr;

  smbrd_dp #(
    .MEM_AW(MEM_AW), .SYNC_STAGES(SYNC_STAGES), .BLOCK_LEN(BLOCK_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .memData(memData), .memAddr(memAddr), .sclLevel(sclLevel),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .sdaBit(sdaBit), .rxByte(rxByte), .txMsb(txMsb),
    .crcVal(crcVal)
  );

  smbrd_ctrl #(
    .SLAVE_ADDR(SLAVE_ADDR), .BLOCK_CMD(BLOCK_CMD), .BLOCK_LEN(BLOCK_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .rxByte(rxByte), .txMsb(txMsb), .pecEn(pecEn), .strobe(strobe),
    .sdaOe(sdaOe), .state(state), .armed(armed)
  );

  assign incPtr = strobe.incPtr;

endmodule

// File: rtl/smbrd_chk.sv
module smbrd_chk
  import smbrd_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLevel,
  input logic              sdaOe,
  input logic              startDet,
  input logic              stopDet,
  input logic              incPtr,
  input logic              armed,
  input logic [MEM_AW-1:0] memAddr,
  input state_e            state,
  input logic [7:0]        crcVal
);

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

  a_r3_ptr_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
    incPtr |=> memAddr == MEM_AW'($past(memAddr) + 1'b1));

  a_r9_start_rematches: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet) |=> state == ST_RX);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe && !armed);

  a_r6_crc_fresh: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet && !armed) |=> crcVal == 8'h00);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaOe);

endmodule

bind smbrd_engine smbrd_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaOe(sdaOe),
  .startDet(startDet), .stopDet(stopDet), .incPtr(incPtr), .armed(armed),
  .memAddr(memAddr), .state(state), .crcVal(crcVal)
);

// File: tb/sim_smbrd_engine.sv
module sim_smbrd_engine;

  localparam int         AW    = 6;
  localparam int         MEMN  = 1 << AW;
  localparam int         BLK   = 32;
  localparam logic [6:0] SADDR = 7'h2A;
  localparam logic [7:0] ADDR_W = {SADDR, 1'b0};
  localparam logic [7:0] ADDR_R = {SADDR, 1'b1};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          sclM = 1'b1;
  logic          mLow = 1'b0;
  logic          pecEn = 1'b0;
  logic          sdaOe, sdaBus;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;

  assign sdaBus = !(mLow || sdaOe);

  smbrd_engine u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .pecEn(pecEn), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] memVal(int i);
    return 8'((i % MEMN) * 37 + 11);
  endfunction

  always_ff @(posedge clk) memData <= memVal(int'(memAddr));

  function automatic logic [7:0] crcByte(logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  int nChecks = 0;
  int nFails  = 0;
  int ptrM    = 0;
  logic [7:0] crcM;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsByte;
  event       gotByte;

  task automatic expectByte(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  initial forever begin
    @(gotByte);
    if (expQ.size() == 0) check(1'b0, "R4 unexpected byte", int'(obsByte), 0);
    else begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(obsByte == e, t, int'(obsByte), int'(e));
    end
  end

  // bit-level master
  task automatic qtr();
    repeat (5) @(negedge clk);
  endtask

  task automatic mBit(input logic b, output logic sEarly, output logic sLate);
    mLow = !b;
    qtr();
    sclM = 1'b1;
    repeat (2) @(negedge clk);
    sEarly = sdaBus;
    repeat (7) @(negedge clk);
    sLate = sdaBus;
    @(negedge clk);
    sclM = 1'b0;
    qtr();
  endtask

  task automatic mStart();
    mLow = 1'b0;
    qtr();
    sclM = 1'b1;
    qtr();
    mLow = 1'b1;
    qtr();
    sclM = 1'b0;
    qtr();
  endtask

  task automatic mStop();
    mLow = 1'b1;
    qtr();
    sclM = 1'b1;
    qtr();
    mLow = 1'b0;
    qtr();
  endtask

  task automatic mWrite(input logic [7:0] b, output logic ack);
    logic e, l;
    for (int i = 7; i >= 0; i--) mBit(b[i], e, l);
    mBit(1'b1, e, l);
    ack = !l;
    if (ack) check(e == l, "R10 ack held through high phase", int'(e), int'(l));
  endtask

  task automatic mRead(input logic giveAck, input logic toMon, output logic [7:0] b);
    logic e, l, steady;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, e, l);
      b[i] = l;
      if (e != l) steady = 1'b0;
    end
    mBit(!giveAck, e, l);
    check(steady, "R10 data bits steady while SCL high", int'(steady), 1);
    if (toMon) begin
      obsByte = b;
      ->gotByte;
    end
  endtask

  task automatic sendByteTx(input logic [7:0] v);
    logic ack;
    mStart();
    mWrite(ADDR_W, ack);
    check(ack, "R1 address acknowledged", int'(ack), 1);
    mWrite(v, ack);
    check(ack, "R2 pointer byte acknowledged", int'(ack), 1);
    mStop();
    ptrM = int'(v) % MEMN;
    check(int'(memAddr) == ptrM, "R2 pointer loaded", int'(memAddr), ptrM);
  endtask

  task automatic recvByteTx(input string tag);
    logic ack;
    logic [7:0] b;
    mStart();
    mWrite(ADDR_R, ack);
    check(ack, "R3 read address acknowledged", int'(ack), 1);
    expectByte(memVal(ptrM), tag);
    mRead(1'b0, 1'b1, b);
    mStop();
    ptrM = (ptrM + 1) % MEMN;
    check(int'(memAddr) == ptrM, "R3 pointer advanced", int'(memAddr), ptrM);
  endtask

  // nData data bytes read; NACK on the last one when fewer than BLK
  task automatic blockTx(input int nData, input logic withPec, input logic probe,
                         input string tag);
    logic ack;
    logic [7:0] b, v;
    crcM = 8'h00;
    mStart();
    mWrite(ADDR_W, ack);
    check(ack, "R4 write address acknowledged", int'(ack), 1);
    crcM = crcByte(crcM, ADDR_W);
    mWrite(8'hFD, ack);
    check(ack, "R4 block command acknowledged", int'(ack), 1);
    crcM = crcByte(crcM, 8'hFD);
    mStart();
    mWrite(ADDR_R, ack);
    check(ack, "R4 read address acknowledged", int'(ack), 1);
    crcM = crcByte(crcM, ADDR_R);
    expectByte(8'h20, "R4 count byte");
    mRead(1'b1, 1'b1, b);
    crcM = crcByte(crcM, 8'h20);
    for (int k = 0; k < nData; k++) begin
      v = memVal(ptrM);
      expectByte(v, tag);
      mRead(!(k == nData - 1 && nData < BLK), 1'b1, b);
      crcM = crcByte(crcM, v);
      ptrM = (ptrM + 1) % MEMN;
    end
    if (nData == BLK && withPec) begin
      expectByte(crcM, "R6 checksum byte");
      mRead(1'b0, 1'b1, b);
    end
    if (probe) begin
      mRead(1'b0, 1'b0, b);
      check(b == 8'hFF, nData < BLK ? "R8 released after early NACK"
                                    : "R7 nothing after last data byte",
            int'(b), 8'hFF);
    end
    mStop();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(sdaOe == 1'b0, "R11 SDA released in reset", int'(sdaOe), 0);
    check(memAddr == '0, "R11 pointer zero in reset", int'(memAddr), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    sendByteTx(8'h05);
    recvByteTx("R3 single read");
    recvByteTx("R3 second single read");

    // R1 foreign address
    mStart();
    mWrite({7'h2B, 1'b0}, ack);
    check(!ack, "R1 foreign address not acknowledged", int'(ack), 0);
    mWrite(8'h11, ack);
    check(!ack, "R1 following byte ignored", int'(ack), 0);
    mStop();
    check(int'(memAddr) == ptrM, "R1 pointer untouched", int'(memAddr), ptrM);

    // R5 and R6: block with checksum across the wrap
    pecEn = 1'b1;
    sendByteTx(8'h28);
    blockTx(BLK, 1'b1, 1'b0, "R5 block data across wrap");
    check(int'(memAddr) == ptrM, "R5 pointer after wrap", int'(memAddr), ptrM);

    // R7: block without checksum
    pecEn = 1'b0;
    blockTx(BLK, 1'b0, 1'b1, "R7 block data");
    check(int'(memAddr) == ptrM, "R4 pointer after block", int'(memAddr), ptrM);

    // R8: early NACK on the fifth data byte
    pecEn = 1'b1;
    blockTx(5, 1'b1, 1'b1, "R8 data before NACK");
    check(int'(memAddr) == ptrM, "R8 pointer after early NACK", int'(memAddr), ptrM);
    recvByteTx("R8 read after early NACK");

    // R9: stop cancels a pending block command; pointer byte masked to 6 bits
    sendByteTx(8'hC9);
    mStart();
    mWrite(ADDR_W, ack);
    mWrite(8'hFD, ack);
    check(ack, "R9 block command acknowledged", int'(ack), 1);
    mStop();
    recvByteTx("R9 single read after cancelled block");

    // R9: start in the middle of a byte
    mStart();
    mWrite(ADDR_W, ack);
    begin
      logic e, l;
      mBit(1'b1, e, l);
      mBit(1'b0, e, l);
      mBit(1'b1, e, l);
    end
    recvByteTx("R9 read after mid-byte restart");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected bytes seen", expQ.size(), 0);
    check(sdaOe == 1'b0, "R9 bus released at end", int'(sdaOe), 0);
    finishRun();
  end

endmodule